// File: doc/BRIEF.md
# Converter Read-Cycle I2C Slave

This block is the digital I2C slave front end of a data converter. It keeps track of where the converter is in its cycle: converting, asleep with a result ready, or sending that result out. It links the bus handshake to that cycle. The slave answers to a 7-bit address chosen by two three-level strap pins, and also to a global address. It acknowledges a read only when a result is waiting. It sends the 32-bit result MSB first. A new conversion starts as soon as the read completes or is cut short.

SDA is modelled as an open-drain line. `sda_oe` pulls the line low and `sda_i` returns the resolved line level. Conversion time is modelled by an internal cycle counter, and the result word is sampled from `result_i` when that count expires. A configuration word is loaded through a side port and held across cycles. Decoding configuration writes from the bus is handled elsewhere, so a write-direction address is refused.

Top module: `i2c_conv_slave`

## Requirements
- R1: While reset is asserted and just after it is released, `busy_o` is 1 (the power-up conversion is running), `sda_oe` is 0 and `cfg_o` equals CFG_DEFAULT (8'hC0).
- R2: A conversion keeps `busy_o` high for exactly CONV_CYCLES clock cycles, counted from the cycle in which reset is released or the conversion starts. The block then sleeps with `busy_o` low. `result_i` is captured at the end of the conversion, and later changes on `result_i` do not alter the word that is read.
- R3: A Start followed by the selected address or the global address 7'h77 with R/W = 1 (read) is ACKed (SDA low in the ninth clock) while the block sleeps, and the block enters the output state.
- R4: A matching read address received while a conversion runs is NAKed (SDA left high). The running conversion completes normally.
- R5: An address that matches neither the selected nor the global address, or any address with R/W = 0, is NAKed. A sleeping block stays asleep, with its result still readable.
- R6: The result is sent MSB first, as four bytes. SDA changes only while SCL is low, and SDA is released during each master acknowledge slot.
- R7: When the 32nd data bit ends (SCL falls), the output state ends and a new conversion starts.
- R8: A master NAK, a Stop or a repeated Start in the ninth clock after a data byte ends the output state and starts a new conversion. Until that slot, the output state persists.
- R9: Pin codes: 0 = low, 1 = high, 2 = floating, 3 = treated as floating. The table index is 3*code(pin_b)+code(pin_a). The default table maps index 0..8 to 7'h14, 7'h15, 7'h16, 7'h17, 7'h24, 7'h25, 7'h26, 7'h27, 7'h34. The pins are sampled only while reset is asserted.
- R10: A pulse on `cfg_load` stores `cfg_data` into `cfg_o`. Without a load, `cfg_o` keeps its value through any number of reads and conversions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Resolved bus data level |
| sda_oe | output | 1 | Pull SDA low when 1 |
| pin_a | input | 2 | First strap pin code |
| pin_b | input | 2 | Second strap pin code |
| result_i | input | RES_W | Conversion result from the converter |
| cfg_load | input | 1 | Load strobe for the configuration |
| cfg_data | input | CFG_W | New configuration word |
| cfg_o | output | CFG_W | Held configuration word |
| busy_o | output | 1 | High while a conversion runs |

## Verification
The embedded assertions watch four things on every cycle. SDA is driven only in the address-acknowledge slot and during data bits. An acknowledge slot is never entered while a conversion runs. Leaving the output state always lands in a conversion, and sleep is reached only from a conversion. They also check that the configuration and the strapped address stay put when they should. Only the bench's bus scenarios can show the actual bytes and their order, the exact conversion length, and which slot an abort must fall into. They also show which addresses are acknowledged after straps are changed and re-sampled.

// File: rtl/i2c_conv_slave.sv
module i2c_conv_slave #(
  parameter int CONV_CYCLES = 2000,
  parameter int RES_W = 32,
  parameter int CFG_W = 8,
  parameter logic [CFG_W-1:0] CFG_DEFAULT = 8'hC0,
  parameter logic [6:0] GLOBAL_ADDR = 7'h77,
  parameter logic [62:0] ADDR_TABLE = {7'h34, 7'h27, 7'h26, 7'h25, 7'h24,
                                       7'h17, 7'h16, 7'h15, 7'h14}
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  input  logic [1:0]       pin_a,
  input  logic [1:0]       pin_b,
  input  logic [RES_W-1:0] result_i,
  input  logic             cfg_load,
  input  logic [CFG_W-1:0] cfg_data,
  output logic [CFG_W-1:0] cfg_o,
  output logic             busy_o
);
  localparam int CW = $clog2(CONV_CYCLES + 1);
  localparam int NBYTES = RES_W / 8;
  localparam int BCW = $clog2(NBYTES + 1);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_ADEC, S_ACKA, S_SEND, S_MACK, S_SKIP} bus_t;
  typedef enum logic [1:0] {P_CONV, P_SLEEP, P_OUT} phase_t;

  bus_t             st;
  phase_t           phase;
  logic [CW-1:0]    cnt;
  logic [RES_W-1:0] res_q, dsh;
  logic [7:0]       shreg;
  logic [2:0]       bitc;
  logic [BCW-1:0]   bytec;
  logic             oe_q, mnak;
  logic             scl_q, scl_p, sda_q, sda_p;
  logic [6:0]       dev_addr;
  logic [CFG_W-1:0] cfg_q;

  logic [1:0] code_a, code_b;
  logic [3:0] sel_idx;
  assign code_a  = (pin_a == 2'd3) ? 2'd2 : pin_a;
  assign code_b  = (pin_b == 2'd3) ? 2'd2 : pin_b;
  assign sel_idx = {2'b00, code_b} * 4'd3 + {2'b00, code_a};

  always_ff @(posedge clk)
    if (!rst_n) dev_addr <= ADDR_TABLE[7*sel_idx +: 7];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_q <= 1'b1; scl_p <= 1'b1; sda_q <= 1'b1; sda_p <= 1'b1;
    end else begin
      scl_q <= scl_i; scl_p <= scl_q; sda_q <= sda_i; sda_p <= sda_q;
    end

  logic scl_rise, scl_fall, start_ev, stop_ev, bus_ev, match, last_bit, last_byte;
  logic enter_out, end_out;
  assign scl_rise  = scl_q & ~scl_p;
  assign scl_fall  = ~scl_q & scl_p;
  assign start_ev  = scl_q & scl_p & sda_p & ~sda_q;
  assign stop_ev   = scl_q & scl_p & ~sda_p & sda_q;
  assign bus_ev    = (start_ev | stop_ev) & (st != S_SEND);
  assign match     = (shreg[7:1] == dev_addr) || (shreg[7:1] == GLOBAL_ADDR);
  assign last_bit  = (bitc == 3'd7);
  assign last_byte = (bytec == BCW'(NBYTES));
  assign enter_out = (st == S_ACKA) && scl_fall;
  assign end_out   = (phase == P_OUT) &&
                     ((bus_ev && st == S_MACK) ||
                      (!bus_ev && st == S_SEND && scl_fall && last_bit && last_byte) ||
                      (!bus_ev && st == S_MACK && scl_fall && mnak));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      phase <= P_CONV;
      cnt   <= CW'(CONV_CYCLES - 1);
      res_q <= '0;
    end else if (phase == P_CONV) begin
      if (cnt == '0) begin
        phase <= P_SLEEP;
        res_q <= result_i;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end else if (phase == P_SLEEP && enter_out) begin
      phase <= P_OUT;
    end else if (end_out) begin
      phase <= P_CONV;
      cnt   <= CW'(CONV_CYCLES - 1);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; oe_q <= 1'b0; mnak <= 1'b0;
      shreg <= '0; dsh <= '0; bitc <= '0; bytec <= '0;
    end else if (bus_ev) begin
      oe_q <= 1'b0;
      bitc <= '0;
      st   <= start_ev ? S_ADDR : S_IDLE;
    end else begin
      case (st)
        S_ADDR: if (scl_rise) begin
          shreg <= {shreg[6:0], sda_q};
          bitc  <= bitc + 1'b1;
          if (last_bit) st <= S_ADEC;
        end
        S_ADEC: if (scl_fall) begin
          if (match && shreg[0] && phase == P_SLEEP) begin
            oe_q <= 1'b1;
            st   <= S_ACKA;
          end else begin
            st <= S_SKIP;
          end
        end
        S_ACKA: if (scl_fall) begin
          dsh   <= res_q;
          oe_q  <= ~res_q[RES_W-1];
          bitc  <= '0;
          bytec <= BCW'(1);
          st    <= S_SEND;
        end
        S_SEND: if (scl_fall) begin
          if (last_bit) begin
            oe_q <= 1'b0;
            if (last_byte) st <= S_SKIP;
            else begin
              bytec <= bytec + 1'b1;
              st    <= S_MACK;
            end
          end else begin
            dsh  <= dsh << 1;
            oe_q <= ~dsh[RES_W-2];
          end
          bitc <= bitc + 1'b1;
        end
        S_MACK: begin
          if (scl_rise) mnak <= sda_q;
          if (scl_fall) begin
            if (mnak) st <= S_SKIP;
            else begin
              dsh  <= dsh << 1;
              oe_q <= ~dsh[RES_W-2];
              bitc <= '0;
              st   <= S_SEND;
            end
          end
        end
        default: ;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cfg_q <= CFG_DEFAULT;
    else if (cfg_load) cfg_q <= cfg_data;

  assign sda_oe = oe_q;
  assign busy_o = (phase == P_CONV);
  assign cfg_o  = cfg_q;

  assert_drive_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> (st == S_ACKA || st == S_SEND));

  assert_ack_only_asleep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ACKA) |-> (phase == P_SLEEP));

  assert_output_ends_in_conv_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(phase) == P_OUT && phase != P_OUT) |-> busy_o);

  assert_sleep_from_conv_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == P_SLEEP && $past(phase) != P_SLEEP) |-> ($past(phase) == P_CONV));

  assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfg_load) |-> $stable(cfg_o));

  assert_addr_fixed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(dev_addr));
endmodule

// File: tb/i2c_conv_slave_tb.sv
module i2c_conv_slave_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N_CONV = 300;
  localparam int H = 6;
  localparam int NV = 6;
  localparam logic [31:0] V_RES [NV] = '{32'hA5C30F96, 32'h12345678, 32'hFFFF0001,
                                         32'h80000000, 32'h00FF7E81, 32'h3C5AA5C3};
  localparam int V_MODE [NV] = '{0, 1, 2, 0, 3, 1};
  localparam int V_NB   [NV] = '{4, 1, 2, 4, 3, 3};

  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_oe, busy_o, cfg_load = 1'b0;
  logic [1:0] pin_a = 2'd0, pin_b = 2'd0;
  logic [31:0] result_i = '0;
  logic [7:0] cfg_data = '0, cfg_o;
  logic sda_line;
  int n_chk = 0, n_fail = 0;

  assign sda_line = m_sda & ~sda_oe;
  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_conv_slave #(.CONV_CYCLES(N_CONV)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .pin_a(pin_a), .pin_b(pin_b), .result_i(result_i), .cfg_load(cfg_load),
    .cfg_data(cfg_data), .cfg_o(cfg_o), .busy_o(busy_o));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wt(input int n); repeat (n) @(negedge clk); endtask
  task automatic bstart(); m_sda = 1; m_scl = 1; wt(H); m_sda = 0; wt(H); m_scl = 0; wt(H); endtask
  task automatic bstop(); m_sda = 0; wt(H); m_scl = 1; wt(H); m_sda = 1; wt(H); endtask
  task automatic wbit(input logic b); m_sda = b; wt(H); m_scl = 1; wt(H); m_scl = 0; wt(H); endtask
  task automatic rbit(output logic b);
    m_sda = 1; wt(H); m_scl = 1; wt(H/2); b = sda_line; wt(H - H/2); m_scl = 0; wt(H);
  endtask
  task automatic do_addr(input logic [6:0] a, input logic rw, output logic ack);
    logic b;
    for (int i = 6; i >= 0; i--) wbit(a[i]);
    wbit(rw);
    rbit(b);
    ack = !b;
  endtask
  task automatic rd_byte(output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin rbit(b); d[i] = b; end
  endtask
  task automatic wait_sleep();
    int t = 0;
    while (busy_o && t < 4000) begin wt(1); t++; end
    chk(!busy_o, "R2 sleep reached", 32'(busy_o), 0);
  endtask
  task automatic full_read(input logic [6:0] a, input logic [31:0] expv, input string req);
    logic ack;
    logic [7:0] d;
    bstart();
    do_addr(a, 1'b1, ack);
    chk(ack, {req, " R3 ack"}, 32'(ack), 1);
    for (int b = 0; b < 4; b++) begin
      rd_byte(d);
      chk(d == expv[31-8*b -: 8], {req, " R6 byte"}, 32'(d), 32'(expv[31-8*b -: 8]));
      if (b < 3) wbit(1'b0);
    end
    chk(busy_o, {req, " R7 conversion after 32 bits"}, 32'(busy_o), 1);
    wbit(1'b1);
    bstop();
  endtask
  task automatic do_reset();
    rst_n = 0; wt(4);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] d;
    int n;
    result_i = 32'hC0FFEE11;
    do_reset();
    chk(sda_oe == 0, "R1 sda released", 32'(sda_oe), 0);
    chk(busy_o == 1, "R1 busy in reset", 32'(busy_o), 1);
    chk(cfg_o == 8'hC0, "R1 cfg default", 32'(cfg_o), 32'hC0);
    rst_n = 1;
    n = 0;
    while (busy_o && n < 5000) begin n++; @(negedge clk); end
    chk(n == N_CONV, "R2 conversion length", n, N_CONV);

    bstart(); do_addr(7'h15, 1'b1, ack); bstop();
    chk(!ack, "R5 wrong address NAK", 32'(ack), 0);
    bstart(); do_addr(7'h14, 1'b0, ack); bstop();
    chk(!ack, "R5 write direction NAK", 32'(ack), 0);
    chk(!busy_o, "R5 still asleep", 32'(busy_o), 0);

    full_read(7'h77, 32'hC0FFEE11, "R3 global");
    bstart(); do_addr(7'h14, 1'b1, ack); bstop();
    chk(!ack, "R4 NAK while converting", 32'(ack), 0);
    chk(busy_o, "R4 conversion continues", 32'(busy_o), 1);

    for (int v = 0; v < NV; v++) begin
      result_i = V_RES[v];
      chk(busy_o, "R7 R8 converting before vector", 32'(busy_o), 1);
      wait_sleep();
      bstart();
      do_addr(7'h14, 1'b1, ack);
      chk(ack, "R3 vector ack", 32'(ack), 1);
      for (int b = 0; b < V_NB[v]; b++) begin
        rd_byte(d);
        chk(d == V_RES[v][31-8*b -: 8], "R6 vector byte", 32'(d), 32'(V_RES[v][31-8*b -: 8]));
        if (b < V_NB[v] - 1) wbit(1'b0);
      end
      if (V_MODE[v] == 0) begin
        chk(busy_o, "R7 conversion after 32 bits", 32'(busy_o), 1);
        wbit(1'b1); bstop();
      end else begin
        chk(!busy_o, "R8 output held until ack slot", 32'(busy_o), 0);
        if (V_MODE[v] == 1) begin
          bstop(); wt(3);
          chk(busy_o, "R8 stop abort", 32'(busy_o), 1);
        end else if (V_MODE[v] == 2) begin
          wbit(1'b1); wt(3);
          chk(busy_o, "R8 master NAK abort", 32'(busy_o), 1);
          bstop();
        end else begin
          bstart();
          chk(busy_o, "R8 restart abort", 32'(busy_o), 1);
          do_addr(7'h14, 1'b1, ack);
          chk(!ack, "R4 NAK after restart", 32'(ack), 0);
          bstop();
        end
      end
    end

    result_i = 32'h5EED1234;
    wait_sleep();
    result_i = 32'hDEADBEEF;
    full_read(7'h14, 32'h5EED1234, "R2 capture");

    cfg_data = 8'h3C; cfg_load = 1; wt(1); cfg_load = 0; wt(1);
    chk(cfg_o == 8'h3C, "R10 cfg load", 32'(cfg_o), 32'h3C);
    wait_sleep();
    full_read(7'h14, 32'hDEADBEEF, "R10 read");
    wait_sleep();
    chk(cfg_o == 8'h3C, "R10 cfg held", 32'(cfg_o), 32'h3C);

    pin_a = 2'd1; pin_b = 2'd2;
    do_reset();
    rst_n = 1;
    chk(cfg_o == 8'hC0, "R10 default after reset", 32'(cfg_o), 32'hC0);
    wait_sleep();
    pin_a = 2'd0; pin_b = 2'd0;
    bstart(); do_addr(7'h14, 1'b1, ack); bstop();
    chk(!ack, "R9 pins ignored after reset", 32'(ack), 0);
    bstart(); do_addr(7'h27, 1'b1, ack);
    chk(ack, "R9 strap index 7", 32'(ack), 1);
    rd_byte(d); wbit(1'b1); bstop();

    pin_a = 2'd3; pin_b = 2'd0;
    do_reset();
    rst_n = 1;
    wait_sleep();
    bstart(); do_addr(7'h16, 1'b1, ack);
    chk(ack, "R9 code 3 as floating", 32'(ack), 1);
    rd_byte(d); wbit(1'b1); bstop();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule